// File: doc/BRIEF.md
# Transmit IPv4 and TCP/UDP Checksum Inserter

This block sits in a transmit path and fills in the IPv4 header checksum and the TCP or UDP checksum of an outgoing Ethernet frame. Each frame arrives as a stream of bytes and is stored whole in an internal buffer. While the bytes arrive, the header is parsed and both one's-complement sums are accumulated. Once the last byte is in, the two checksums are finished in one cycle. The frame is then read back out of the buffer, and the checksum values replace the bytes in their header fields as they pass.

Insertion is requested per frame by a flag that travels with the first byte. The block leaves a frame byte-exact when insertion is not requested. It also leaves the frame unchanged in each of these cases: the frame is not IPv4, it is not TCP or UDP, its IPv4 header carries options, it is a fragment, or it is too short for its own length fields. Padding, FCS and line timing belong to other blocks.

Both byte streams use valid/ready. An input byte is taken on a cycle where `in_valid` and `in_ready` are both high. The block lowers `in_ready` from the last byte of a frame until that frame has fully left. An output byte is taken on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the block holds `out_valid`, `out_data` and `out_last` unchanged.

Top module: `txck_insert`

## Requirements
- R1: `in_ready` is high whenever the block is collecting a frame. A byte is taken only on a cycle with `in_valid` and `in_ready` both high. `in_csum_en` is sampled only with the first byte of a frame, and its value on later bytes has no effect.
- R2: When `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` all keep their values into the next cycle.
- R3: No output byte appears before the last input byte has been taken. `out_valid` first rises two cycles after the clock edge that takes the last input byte. `in_ready` stays low from that edge until the edge that takes the last output byte, and it is high again in the next cycle.
- R4: On an eligible frame, bytes 24 (high) and 25 (low) carry the one's complement of the folded one's-complement sum of the 16-bit big-endian words at bytes 14..33, with bytes 24..25 counted as zero.
- R5: On an eligible TCP frame (protocol byte 23 = 6), bytes 50..51 carry a checksum. It is the one's complement of the folded sum of four parts: the source and destination address words at bytes 26..33, the protocol value, the L4 length, and the words at bytes 34 to 13+T. T is the total length at bytes 16..17, the L4 length is T−20, a lone last byte is padded with a zero low byte, and bytes 50..51 count as zero.
- R6: On an eligible UDP frame (protocol 17), the same checksum goes into bytes 40..41 with bytes 40..41 counted as zero. A computed value of 0x0000 is sent as 0xFFFF.
- R7: A frame is eligible only if all of these hold: insertion was requested, bytes 12..13 equal 0x0800, byte 14 equals 0x45, the protocol is 6 or 17, and the fragment conditions of R8 hold. A byte 14 of 0x46 (header options) gives a byte-exact frame.
- R8: A frame with the more-fragments flag (byte 20 bit 5) set, or with a nonzero fragment offset ({byte 20 bits 4..0, byte 21}), is forwarded byte-exact. The don't-fragment flag (byte 20 bit 6) does not block insertion.
- R9: A frame whose first byte came with `in_csum_en` low is forwarded byte-exact.
- R10: Frames with a type other than 0x0800, or with a protocol other than 6 or 17, are forwarded byte-exact.
- R11: Bytes past 13+T are forwarded unchanged and left out of the L4 sum. A frame shorter than 14+T bytes, or with T below 40 (TCP) or 28 (UDP), is forwarded byte-exact.
- R12: During and after reset, `in_ready` is high and `out_valid` is low. A reset in the middle of a frame discards it, and the next frame is handled normally.
- R13: Frames from 1 byte up to DEPTH bytes are forwarded with every byte in order and `out_last` on the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the frame's last |
| in_csum_en | input | 1 | Insertion request, sampled with the first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the frame's last |

## Verification
The first output byte is due exactly two cycles after the edge that takes the last input byte: one cycle finishes the checksums and one loads the first byte from the buffer. After that, each output byte follows one cycle after the previous handshake, for as long as `out_ready` is held high. The bench counts clock edges from the last input handshake and samples `out_valid` on falling edges, so the two-cycle start is checked exactly. It runs frames with gaps in `in_valid` and with a periodic `out_ready` stall, and it checks that stalled data holds its value. Every byte is compared with a frame that the bench builds and checksums itself.

// File: rtl/txck_pkg.sv
package txck_pkg;

  localparam logic [15:0] OFS_ETYPE  = 16'd12;
  localparam logic [15:0] OFS_VIHL   = 16'd14;
  localparam logic [15:0] OFS_TLEN   = 16'd16;
  localparam logic [15:0] OFS_FLAG   = 16'd20;
  localparam logic [15:0] OFS_PROTO  = 16'd23;
  localparam logic [15:0] OFS_IPCK   = 16'd24;
  localparam logic [15:0] OFS_ADDR   = 16'd26;
  localparam logic [15:0] OFS_L4     = 16'd34;
  localparam logic [15:0] OFS_UDPCK  = 16'd40;
  localparam logic [15:0] OFS_TCPCK  = 16'd50;
  localparam logic [15:0] IP_HLEN    = 16'd20;
  localparam logic [15:0] MIN_T_TCP  = 16'd40;
  localparam logic [15:0] MIN_T_UDP  = 16'd28;
  localparam logic [15:0] ETH_IPV4   = 16'h0800;
  localparam logic [7:0]  VIHL_PLAIN = 8'h45;
  localparam logic [7:0]  PROTO_TCP  = 8'd6;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;

  typedef enum logic [1:0] {ST_FILL, ST_CALC, ST_DRAIN} txck_state_t;

  typedef struct packed {
    logic        ok;
    logic        is_udp;
    logic [15:0] ip_ck;
    logic [15:0] l4_ck;
  } ck_res_t;

  function automatic logic [15:0] fold32(input logic [31:0] a);
    logic [16:0] s1;
    logic [16:0] s2;
    s1 = {1'b0, a[15:0]} + {1'b0, a[31:16]};
    s2 = {1'b0, s1[15:0]} + {16'h0, s1[16]};
    return s2[15:0] + {15'h0, s2[16]};
  endfunction

endpackage

// File: rtl/txck_hdr_parse.sv
module txck_hdr_parse
  import txck_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic [15:0] pos,
  input  logic [7:0]  data,
  input  logic        csum_en,
  output logic        en_q,
  output logic [15:0] etype,
  output logic [7:0]  vihl,
  output logic [15:0] tlen,
  output logic [7:0]  fhi,
  output logic [7:0]  flo,
  output logic [7:0]  proto,
  output logic [31:0] ip_acc,
  output logic [31:0] l4_acc
);

  logic [15:0] word;
  logic [16:0] l4_end;
  logic [15:0] ck_pos;
  logic        in_ip;
  logic        in_l4;

  always_comb begin
    word   = pos[0] ? {8'h00, data} : {data, 8'h00};
    l4_end = {1'b0, tlen} + 17'd14;
    ck_pos = (proto == PROTO_UDP) ? OFS_UDPCK : OFS_TCPCK;
    in_ip  = (pos >= OFS_VIHL) && (pos < OFS_L4) &&
             (pos != OFS_IPCK) && (pos != OFS_IPCK + 16'd1);
    in_l4  = ((pos >= OFS_ADDR) && (pos < OFS_L4)) ||
             ((pos >= OFS_L4) && ({1'b0, pos} < l4_end) &&
              (pos != ck_pos) && (pos != ck_pos + 16'd1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      etype  <= '0;
      vihl   <= '0;
      tlen   <= '0;
      fhi    <= '0;
      flo    <= '0;
      proto  <= '0;
      ip_acc <= '0;
      l4_acc <= '0;
    end else if (beat) begin
      if (pos == 16'd0) begin
        en_q   <= csum_en;
        etype  <= '0;
        vihl   <= '0;
        tlen   <= '0;
        fhi    <= '0;
        flo    <= '0;
        proto  <= '0;
        ip_acc <= '0;
        l4_acc <= '0;
      end else begin
        if (in_ip) ip_acc <= ip_acc + {16'h0, word};
        if (in_l4) l4_acc <= l4_acc + {16'h0, word};
        case (pos)
          OFS_ETYPE:          etype[15:8] <= data;
          OFS_ETYPE + 16'd1:  etype[7:0]  <= data;
          OFS_VIHL:           vihl        <= data;
          OFS_TLEN:           tlen[15:8]  <= data;
          OFS_TLEN + 16'd1:   tlen[7:0]   <= data;
          OFS_FLAG:           fhi         <= data;
          OFS_FLAG + 16'd1:   flo         <= data;
          OFS_PROTO:          proto       <= data;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/txck_buf.sv
module txck_buf #(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/txck_egress.sv
module txck_egress
  import txck_pkg::*;
#(
  parameter int AW    = 11,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] flen,
  input  ck_res_t          res,
  input  logic [7:0]       rd_data,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             done
);

  logic [CNT_W-1:0] ptr;
  logic             pending;
  logic             sel_q;
  logic [7:0]       val_q;
  logic             adv;
  logic             sub;
  logic [7:0]       sub_val;
  logic [15:0]      pos;
  logic [15:0]      ck_pos;
  logic             at_end;

  always_comb begin
    adv     = !out_valid || out_ready;
    rd_en   = adv && pending;
    rd_addr = ptr[AW-1:0];
    pos     = 16'(ptr);
    at_end  = (ptr == flen - 1'b1);
    ck_pos  = res.is_udp ? OFS_UDPCK : OFS_TCPCK;
    sub     = 1'b0;
    sub_val = 8'h00;
    if (res.ok) begin
      if (pos == OFS_IPCK) begin
        sub = 1'b1; sub_val = res.ip_ck[15:8];
      end else if (pos == OFS_IPCK + 16'd1) begin
        sub = 1'b1; sub_val = res.ip_ck[7:0];
      end else if (pos == ck_pos) begin
        sub = 1'b1; sub_val = res.l4_ck[15:8];
      end else if (pos == ck_pos + 16'd1) begin
        sub = 1'b1; sub_val = res.l4_ck[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      pending   <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      sel_q     <= 1'b0;
      val_q     <= '0;
    end else if (go) begin
      ptr     <= '0;
      pending <= (flen != '0);
    end else if (adv) begin
      if (pending) begin
        out_valid <= 1'b1;
        out_last  <= at_end;
        sel_q     <= sub;
        val_q     <= sub_val;
        ptr       <= ptr + 1'b1;
        if (at_end) pending <= 1'b0;
      end else begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end

  assign out_data = sel_q ? val_q : rd_data;
  assign done     = out_valid && out_ready && out_last;

endmodule

// File: rtl/txck_insert.sv
module txck_insert
  import txck_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_csum_en,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  txck_state_t      state;
  logic [CNT_W-1:0] wr_cnt;
  logic [CNT_W-1:0] flen_q;
  logic             beat;
  ck_res_t          res_d;
  ck_res_t          res_q;

  logic        en_q;
  logic [15:0] etype;
  logic [7:0]  vihl;
  logic [15:0] tlen;
  logic [7:0]  fhi;
  logic [7:0]  flo;
  logic [7:0]  proto;
  logic [31:0] ip_acc;
  logic [31:0] l4_acc;

  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          done;

  assign in_ready = (state == ST_FILL);
  assign beat     = in_valid && in_ready;

  txck_hdr_parse u_parse (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat),
    .pos     (16'(wr_cnt)),
    .data    (in_data),
    .csum_en (in_csum_en),
    .en_q    (en_q),
    .etype   (etype),
    .vihl    (vihl),
    .tlen    (tlen),
    .fhi     (fhi),
    .flo     (flo),
    .proto   (proto),
    .ip_acc  (ip_acc),
    .l4_acc  (l4_acc)
  );

  txck_buf #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .wr_en   (beat),
    .wr_addr (wr_cnt[AW-1:0]),
    .wr_data (in_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // Checksum finish: eligibility and the two folded complements
  always_comb begin
    logic        is_udp;
    logic        is_l4;
    logic [15:0] min_t;
    logic [31:0] l4_tot;
    logic [15:0] l4_ck;
    is_udp = (proto == PROTO_UDP);
    is_l4  = is_udp || (proto == PROTO_TCP);
    min_t  = is_udp ? MIN_T_UDP : MIN_T_TCP;
    l4_tot = l4_acc + {24'h0, proto} + {16'h0, tlen - IP_HLEN};
    l4_ck  = ~fold32(l4_tot);
    if (is_udp && (l4_ck == 16'h0000)) l4_ck = 16'hFFFF;
    res_d.ok = en_q && (etype == ETH_IPV4) && (vihl == VIHL_PLAIN) &&
               !fhi[5] && ({fhi[4:0], flo} == 13'h0) && is_l4 &&
               (tlen >= min_t) &&
               (17'(flen_q) >= {1'b0, tlen} + 17'd14);
    res_d.is_udp = is_udp;
    res_d.ip_ck  = ~fold32(ip_acc);
    res_d.l4_ck  = l4_ck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_FILL;
      wr_cnt <= '0;
      flen_q <= '0;
      res_q  <= '0;
    end else begin
      case (state)
        ST_FILL: if (beat) begin
          if (in_last) begin
            wr_cnt <= '0;
            flen_q <= wr_cnt + 1'b1;
            state  <= ST_CALC;
          end else begin
            wr_cnt <= wr_cnt + 1'b1;
          end
        end
        ST_CALC: begin
          res_q <= res_d;
          state <= ST_DRAIN;
        end
        ST_DRAIN: if (done) state <= ST_FILL;
        default: state <= ST_FILL;
      endcase
    end
  end

  txck_egress #(.AW(AW), .CNT_W(CNT_W)) u_egress (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (state == ST_CALC),
    .flen      (flen_q),
    .res       (res_q),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .done      (done)
  );

endmodule

// File: rtl/txck_insert_chk.sv
module txck_insert_chk #(
  parameter int DEPTH = 2048,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic [CNT_W-1:0] wr_cnt
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R2

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R3

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready); // R3

  AST_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && !out_valid); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> (32'(wr_cnt) < DEPTH)); // R13

endmodule

bind txck_insert txck_insert_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .wr_cnt    (wr_cnt)
);

// File: tb/txck_insert_bench.sv
`timescale 1ns/1ps
module txck_insert_bench;

  localparam int DEPTH = 2048;

  typedef struct packed {
    bit        en;
    bit [15:0] etype;
    bit [7:0]  vihl;
    bit [7:0]  fhi;
    bit [7:0]  flo;
    bit [7:0]  proto;
    bit [15:0] tlen;
    bit [7:0]  pad;
    bit [7:0]  cut;
    bit        zero;
    bit [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 16'h0800, 8'h45, 8'h00, 8'h00, 8'd6,  16'd60,   8'd0, 8'd0,  1'b0, 4'd5},  // R5 TCP
    '{1'b1, 16'h0800, 8'h45, 8'h00, 8'h00, 8'd17, 16'd48,   8'd0, 8'd0,  1'b0, 4'd6},  // R6 UDP
    '{1'b1, 16'h0800, 8'h45, 8'h00, 8'h00, 8'd6,  16'd46,   8'd6, 8'd0,  1'b0, 4'd11}, // R11 trailing pad
    '{1'b1, 16'h0800, 8'h46, 8'h00, 8'h00, 8'd6,  16'd64,   8'd0, 8'd0,  1'b0, 4'd7},  // R7 options
    '{1'b1, 16'h0800, 8'h45, 8'h20, 8'h00, 8'd17, 16'd48,   8'd0, 8'd0,  1'b0, 4'd8},  // R8 MF set
    '{1'b1, 16'h0800, 8'h45, 8'h00, 8'h10, 8'd6,  16'd60,   8'd0, 8'd0,  1'b0, 4'd8},  // R8 offset
    '{1'b0, 16'h0800, 8'h45, 8'h00, 8'h00, 8'd6,  16'd60,   8'd0, 8'd0,  1'b0, 4'd9},  // R9 disabled
    '{1'b1, 16'h86DD, 8'h45, 8'h00, 8'h00, 8'd6,  16'd60,   8'd0, 8'd0,  1'b0, 4'd10}, // R10 other type
    '{1'b1, 16'h0800, 8'h45, 8'h00, 8'h00, 8'd1,  16'd40,   8'd0, 8'd0,  1'b0, 4'd10}, // R10 other proto
    '{1'b1, 16'h0800, 8'h45, 8'h00, 8'h00, 8'd6,  16'd60,   8'd0, 8'd10, 1'b0, 4'd11}, // R11 truncated
    '{1'b1, 16'h0800, 8'h45, 8'h00, 8'h00, 8'd17, 16'd27,   8'd0, 8'd0,  1'b0, 4'd11}, // R11 T too small
    '{1'b1, 16'h1234, 8'h45, 8'h00, 8'h00, 8'd6,  16'd2034, 8'd0, 8'd0,  1'b0, 4'd13}, // R13 full depth
    '{1'b1, 16'h0800, 8'h45, 8'h00, 8'h00, 8'd6,  16'd61,   8'd0, 8'd0,  1'b0, 4'd5},  // R5 odd length
    '{1'b1, 16'h0800, 8'h45, 8'h00, 8'h00, 8'd17, 16'd48,   8'd0, 8'd0,  1'b1, 4'd6},  // R6 zero to FFFF
    '{1'b1, 16'h0800, 8'h45, 8'h40, 8'h00, 8'd6,  16'd60,   8'd0, 8'd0,  1'b0, 4'd4},  // R4 DF allowed
    '{1'b1, 16'h0800, 8'h45, 8'h00, 8'h00, 8'd6,  16'd0,    8'd0, 8'd13, 1'b0, 4'd13}  // R13 one byte
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_csum_en = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_last;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit wd_hit = 0;

  logic [7:0] frame [DEPTH];
  logic [7:0] expf  [DEPTH];
  logic [7:0] got   [DEPTH];
  int flen;
  int last_cyc;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  txck_insert #(.DEPTH(DEPTH)) u_txck_insert (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_csum_en(in_csum_en),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [15:0] bfold(input bit [31:0] a);
    while (a[31:16] != 16'h0) a = {16'h0, a[15:0]} + {16'h0, a[31:16]};
    return a[15:0];
  endfunction

  function automatic bit [15:0] l4_raw(input bit [15:0] t, input bit [7:0] p);
    bit [31:0] acc = 0;
    int ckp = (p == 8'd17) ? 40 : 50;
    int stop = 14 + int'(t);
    for (int i = 26; i < 34; i += 2) acc += {16'h0, frame[i], frame[i+1]};
    acc += {24'h0, p};
    acc += {16'h0, t - 16'd20};
    for (int i = 34; i < stop; i += 2) begin
      if (i != ckp) acc += {16'h0, frame[i], (i + 1 < stop) ? frame[i+1] : 8'h00};
    end
    return bfold(acc);
  endfunction

  task automatic put(input int i, input bit [7:0] b);
    if (i < flen) frame[i] = b;
  endtask

  task automatic build(input vec_t v);
    flen = 14 + int'(v.tlen) + int'(v.pad) - int'(v.cut);
    for (int i = 0; i < flen; i++) frame[i] = 8'((i * 37 + 11) ^ (i >> 3));
    put(12, v.etype[15:8]); put(13, v.etype[7:0]);
    put(14, v.vihl); put(15, 8'h00);
    put(16, v.tlen[15:8]); put(17, v.tlen[7:0]);
    put(20, v.fhi); put(21, v.flo);
    put(22, 8'd64); put(23, v.proto);
    put(24, 8'hAB); put(25, 8'hCD);
    if (v.zero) begin
      bit [15:0] s;
      frame[42] = 8'h00; frame[43] = 8'h00;
      s = l4_raw(v.tlen, v.proto);
      s = 16'hFFFF - s;
      frame[42] = s[15:8]; frame[43] = s[7:0];
    end
  endtask

  task automatic expect_frame(input vec_t v);
    bit        udp = (v.proto == 8'd17);
    bit        elig;
    bit [31:0] acc = 0;
    bit [15:0] c;
    for (int i = 0; i < flen; i++) expf[i] = frame[i];
    elig = v.en && flen >= 34 && v.etype == 16'h0800 && v.vihl == 8'h45 &&
           !v.fhi[5] && {v.fhi[4:0], v.flo} == 13'h0 &&
           (v.proto == 8'd6 || udp) && int'(v.tlen) >= (udp ? 28 : 40) &&
           flen >= 14 + int'(v.tlen);
    if (elig) begin
      for (int i = 14; i < 34; i += 2) if (i != 24) acc += {16'h0, frame[i], frame[i+1]};
      c = ~bfold(acc);
      expf[24] = c[15:8]; expf[25] = c[7:0];
      c = ~l4_raw(v.tlen, v.proto);
      if (udp && c == 16'h0000) c = 16'hFFFF;
      expf[udp ? 40 : 50] = c[15:8]; expf[udp ? 41 : 51] = c[7:0];
    end
  endtask

  task automatic send(input bit en, input bit gaps);
    for (int i = 0; i < flen; i++) begin
      if (gaps && (i % 5 == 3)) begin in_valid = 1'b0; @(negedge clk); end
      in_valid   = 1'b1;
      in_data    = frame[i];
      in_last    = (i == flen - 1);
      in_csum_en = (i == 0) ? en : !en; // R1: only the first beat counts
      while (!in_ready && !wd_hit) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_csum_en = 1'b0;
    last_cyc = cyc;
  endtask

  task automatic receive(input string req, input bit bp);
    int n = 0, first = -1, hold_bad = 0, rdy_bad = 0, phase = 0, guard = 0, bad_i = -1;
    bit stall = 0, fin = 0;
    logic [7:0] held = 8'h00;
    chk(!in_ready, "R3", int'(in_ready), 0);
    while (!fin && guard < 10000 && !wd_hit) begin
      if (out_valid && first < 0) first = cyc;
      if (stall && !(out_valid && out_data == held)) hold_bad++;
      if (in_ready) rdy_bad++;
      out_ready = bp ? (phase % 3 != 1) : 1'b1;
      phase++;
      stall = out_valid && !out_ready;
      held  = out_data;
      if (out_valid && out_ready) begin
        if (n < DEPTH) got[n] = out_data;
        n++;
        if (out_last) fin = 1;
      end
      guard++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(first - last_cyc == 2, "R3", first - last_cyc, 2);
    chk(hold_bad == 0, "R2", hold_bad, 0);
    chk(rdy_bad == 0, "R3", rdy_bad, 0);
    chk(in_ready && !out_valid, "R3", {in_ready, out_valid}, 2);
    chk(n == flen, req, n, flen);
    for (int i = 0; i < flen && i < n; i++) if (got[i] !== expf[i] && bad_i < 0) bad_i = i;
    if (bad_i >= 0) chk(0, req, {bad_i, 8'h0, got[bad_i]}, {bad_i, 8'h0, expf[bad_i]});
    else chk(1, req, 0, 0);
  endtask

  task automatic run_vec(input vec_t v, input int k);
    build(v);
    expect_frame(v);
    send(v.en, k % 3 == 1);
    receive($sformatf("R%0d", v.req), k % 2 == 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(in_ready && !out_valid, "R12", {in_ready, out_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R12", {in_ready, out_valid}, 2);

    for (int k = 0; k < NVEC; k++) run_vec(VEC[k], k);

    // R12: reset in the middle of a frame, then a normal frame
    build(VEC[0]);
    for (int i = 0; i < 10; i++) begin
      in_valid = 1'b1; in_data = frame[i]; in_csum_en = 1'b1; in_last = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(in_ready && !out_valid, "R12", {in_ready, out_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(VEC[0], 0);
    run_vec(VEC[1], 1); // R6 again after reset with back-pressure

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1;
    tests++;
    fails++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule